// File: doc/BRIEF.md
# Rectangle Fill Engine with Colour Expansion

This block fills rectangles in an 8-bit frame buffer whose rows are 2048 pixels apart. Software first loads several registers: a destination position, a 32-bit pattern word, a foreground colour, a background colour and a control word. It then writes the rectangle size to the size address with the fill opcode bit added. That write starts the walk. The engine covers each row in groups of 32 pixels. Each pattern bit is turned into a foreground pixel, a background pixel or a skipped pixel, and every written pixel appears as one byte write on a simple memory write port.

All register writes pass through a 32-entry queue. The engine drains the queue only while it is not filling, so software can keep writing during a long fill. When a fill finishes, the destination Y register has moved down by the rectangle height, so the next fill lands directly below. A status register shows whether the engine is busy. A second status register gives the number of free queue slots and a sticky flag that records a write lost to a full queue.

The controller has three states:
- S_IDLE: pops one queued write per cycle and applies it. A start entry with non-zero width and height moves to S_PIXEL.
- S_PIXEL: visits one pixel position per cycle. After the last position of the last group of the last row it moves to S_DONE.
- S_DONE: adds the height to Y and returns to S_IDLE.

Top module: `rf_top`

## Requirements
- R1: A write to offset 0x00 loads the destination, with X in bits 31:16 and Y in bits 15:0. A read at 0x00 returns the destination in the same packing.
- R2: A write to 0x04 only loads the size register (width in bits 31:16, height in 15:0) and produces no memory writes. The same data written to 0x44 (size offset plus opcode bit 0x40) starts a fill.
- R3: The pattern word (offset 0x08) is applied most significant bit first: bit 31 controls the leftmost pixel of each 32-pixel group. A set bit writes the foreground colour (offset 0x0C, bits 7:0). An all-ones pattern gives a solid fill.
- R4: A clear pattern bit writes the background colour (offset 0x10, bits 7:0) when control bit 0 (offset 0x14) is 0. When control bit 0 is 1, that pixel is not written.
- R5: With control bit 1 set, no pixel at column width or beyond is written. With control bit 1 clear, each row is widened to the next multiple of 32 pixels.
- R6: A pixel in row r and column c of the rectangle is written to address (Y + r) * 2048 + X + c. Rows go top to bottom, and within a row the groups go left to right.
- R7: After a fill completes, the destination Y read at 0x00 equals the old Y plus the height.
- R8: Bits 31:24 of the read at 0x80 are non-zero while a fill is running or writes are queued, and zero otherwise.
- R9: The queue holds 32 writes. Bits 5:0 of the read at 0x84 give the number of free slots: 32 after reset, and lower by one for each write still waiting.
- R10: A write presented while the queue is full is dropped and has no effect. It sets bit 31 of the read at 0x84, and that bit stays set until reset.
- R11: A start with zero width or zero height makes no memory writes and leaves Y unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset (bit 6 is the fill opcode) |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| mem_we | output | 1 | Pixel byte write strobe |
| mem_addr | output | 32 | Pixel address |
| mem_data | output | 8 | Pixel value |

## Verification
The timing of a register write is as follows:
- The write enters the queue on the edge where it is presented.
- It is applied on the next edge, provided the engine is in S_IDLE.
- A start entry makes the first pixel position appear one cycle after that.
- Each group then takes 32 cycles, whether or not its pixels are written.
- Y changes one cycle after the last position.

The busy flag is therefore set by the half cycle after a write is accepted. The bench samples busy there, and it reads the free-slot count while a long fill blocks the queue, so that the count is exact. The expected pixel writes are compared in order rather than by cycle. Every other result is read only after busy has returned to zero.

// File: rtl/rf_pkg.sv
package rf_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PIXEL = 2'd1,
        S_DONE  = 2'd2
    } fill_state_t;

    localparam logic [7:0] A_DST   = 8'h00;
    localparam logic [7:0] A_SIZE  = 8'h04;
    localparam logic [7:0] A_PAT   = 8'h08;
    localparam logic [7:0] A_FG    = 8'h0C;
    localparam logic [7:0] A_BG    = 8'h10;
    localparam logic [7:0] A_CTRL  = 8'h14;
    localparam logic [7:0] OP_FILL = 8'h40;
    localparam logic [7:0] A_STAT  = 8'h80;
    localparam logic [7:0] A_FREE  = 8'h84;
endpackage

// File: rtl/rf_fifo.sv
module rf_fifo #(
    parameter int W     = 40,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] cnt
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/rf_pix.sv
module rf_pix #(
    parameter int GROUP = 32,
    parameter int CW    = 16,
    parameter int PW    = 8,
    localparam int GW   = $clog2(GROUP)
) (
    input  logic [GROUP-1:0] mask,
    input  logic [GW-1:0]    px,
    input  logic [CW-1:0]    col,
    input  logic [CW-1:0]    width,
    input  logic [PW-1:0]    fg,
    input  logic [PW-1:0]    bg,
    input  logic             transp,
    input  logic             clip,
    output logic             en,
    output logic [PW-1:0]    data
);
    logic bit_v, clipped;

    always_comb begin
        bit_v   = mask[GW'(GROUP - 1) - px];
        clipped = clip && (col >= width);
        en      = !clipped && (bit_v || !transp);
        data    = bit_v ? fg : bg;
    end
endmodule

// File: rtl/rf_top.sv
module rf_top #(
    parameter int DEPTH    = 32,
    parameter int PITCH_LG = 11,
    parameter int GROUP    = 32,
    parameter int PW       = 8,
    localparam int CNTW    = $clog2(DEPTH + 1),
    localparam int GW      = $clog2(GROUP)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [7:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_data
);
    import rf_pkg::*;

    fill_state_t state, state_n;

    logic [15:0]      dst_x, dst_y, w, h, row, grp_base, col, row_y;
    logic [31:0]      pat;
    logic [PW-1:0]    fg, bg, pix_data;
    logic             transp, clip, ovf, busy, pix_en;
    logic [GW-1:0]    px;
    logic [39:0]      f_dout;
    logic             f_full, f_empty, pop;
    logic [CNTW-1:0]  f_cnt;
    logic [7:0]       e_addr;
    logic [31:0]      e_data;
    logic             start_ok, last_px, last_grp, last_row;

    rf_fifo #(.W(40), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .din({wr_addr, wr_data}),
        .pop(pop), .dout(f_dout), .full(f_full), .empty(f_empty), .cnt(f_cnt)
    );

    rf_pix #(.GROUP(GROUP), .CW(16), .PW(PW)) u_pix (
        .mask(pat), .px(px), .col(col), .width(w), .fg(fg), .bg(bg),
        .transp(transp), .clip(clip), .en(pix_en), .data(pix_data)
    );

    assign e_addr   = f_dout[39:32];
    assign e_data   = f_dout[31:0];
    assign pop      = (state == S_IDLE) && !f_empty;
    assign start_ok = (e_addr == (A_SIZE | OP_FILL)) &&
                      (e_data[31:16] != '0) && (e_data[15:0] != '0);
    assign col      = grp_base + 16'(px);
    assign row_y    = dst_y + row;
    assign last_px  = (px == GW'(GROUP - 1));
    assign last_grp = ({1'b0, grp_base} + 17'(GROUP)) >= {1'b0, w};
    assign last_row = (row == h - 16'd1);

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:  if (pop && start_ok) state_n = S_PIXEL;
            S_PIXEL: if (last_px && last_grp && last_row) state_n = S_DONE;
            S_DONE:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // registers and walk counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_x <= '0; dst_y <= '0; w <= '0; h <= '0;
            pat <= '0; fg <= '0; bg <= '0; transp <= 1'b0; clip <= 1'b0;
            row <= '0; grp_base <= '0; px <= '0; ovf <= 1'b0;
        end else begin
            if (wr_en && f_full) ovf <= 1'b1;
            unique case (state)
                S_IDLE: if (pop) begin
                    unique case (e_addr)
                        A_DST:  begin dst_x <= e_data[31:16]; dst_y <= e_data[15:0]; end
                        A_SIZE, A_SIZE | OP_FILL:
                                begin w <= e_data[31:16]; h <= e_data[15:0]; end
                        A_PAT:  pat <= e_data;
                        A_FG:   fg  <= e_data[PW-1:0];
                        A_BG:   bg  <= e_data[PW-1:0];
                        A_CTRL: begin transp <= e_data[0]; clip <= e_data[1]; end
                        default: ;
                    endcase
                    row <= '0; grp_base <= '0; px <= '0;
                end
                S_PIXEL: begin
                    if (!last_px) px <= px + 1'b1;
                    else begin
                        px <= '0;
                        if (!last_grp) grp_base <= grp_base + 16'(GROUP);
                        else begin
                            grp_base <= '0;
                            row      <= row + 16'd1;
                        end
                    end
                end
                S_DONE: dst_y <= dst_y + h;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state != S_IDLE) || !f_empty;
        mem_we   = (state == S_PIXEL) && pix_en;
        mem_addr = ({16'b0, row_y} << PITCH_LG) + {16'b0, dst_x} + {16'b0, col};
        mem_data = pix_data;
        unique case (rd_addr)
            A_DST:   rd_data = {dst_x, dst_y};
            A_STAT:  rd_data = {busy ? 8'h01 : 8'h00, 24'b0};
            A_FREE:  rd_data = {ovf, 25'b0, 6'(CNTW'(DEPTH) - f_cnt)};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int DEPTH = 32,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input rf_pkg::fill_state_t state,
    input logic                mem_we,
    input logic [15:0]         col,
    input logic [15:0]         w,
    input logic [15:0]         h,
    input logic [15:0]         dst_y,
    input logic                clip,
    input logic [CNTW-1:0]     f_cnt,
    input logic                wr_en,
    input logic                pop,
    input logic                ovf,
    input logic [31:0]         rd_data,
    input logic [7:0]          rd_addr
);
    import rf_pkg::*;

    p_clip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && clip) |-> (col < w));

    p_y_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) |=> (dst_y == $past(dst_y) + $past(h)));

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && rd_addr == A_STAT) |-> (rd_data[31:24] != 8'h00));

    p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        f_cnt <= CNTW'(DEPTH));

    p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (f_cnt == CNTW'(DEPTH) && wr_en && !pop) |=> (f_cnt == CNTW'(DEPTH)));

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    p_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (w != '0 && h != '0));

    p_done_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) |-> ($past(state) == S_PIXEL));
endmodule

bind rf_top rf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .mem_we(mem_we), .col(col),
    .w(w), .h(h), .dst_y(dst_y), .clip(clip), .f_cnt(f_cnt), .wr_en(wr_en),
    .pop(pop), .ovf(ovf), .rd_data(rd_data), .rd_addr(rd_addr)
);

// File: tb/rf_top_tb.sv
module rf_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_data;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R3";
    logic [39:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rf_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            rd(8'h80, v);
            if (v[31:24] == 8'h00) return;
        end
    endtask

    // model of expected writes, pushed into the scoreboard
    task automatic expect_fill(input int x, input int y, input int wd, input int ht,
                               input logic [31:0] m, input logic [7:0] f,
                               input logic [7:0] b, input bit tr, input bit cl);
        for (int r = 0; r < ht; r++)
            for (int g = 0; g < wd; g += 32)
                for (int p = 0; p < 32; p++) begin
                    int c = g + p;
                    bit bv = m[31 - p];
                    if (cl && c >= wd) continue;
                    if (!bv && tr) continue;
                    exp_q.push_back({32'((y + r) * 2048 + x + c), bv ? f : b});
                end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected write actual=%h/%h expected=none",
                         cur_tag, mem_addr, mem_data);
            end else begin
                logic [39:0] e;
                e = exp_q.pop_front();
                if ({mem_addr, mem_data} !== e) begin
                    errors++;
                    $display("FAIL %s write actual=%h/%h expected=%h/%h",
                             cur_tag, mem_addr, mem_data, e[39:8], e[7:0]);
                end
            end
        end
    end

    task automatic drain_check(input string tag);
        check(32'(exp_q.size()), 32'd0, {tag, " pending writes"});
        exp_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(8'h80, v); check({24'b0, v[31:24]}, 32'd0, "R8 idle after reset");
        rd(8'h84, v); check(v, 32'd32, "R9 free slots after reset");
        rd(8'h00, v); check(v, 32'd0, "R1 destination after reset");

        // R1 destination packing
        reg_wr(8'h00, {16'd100, 16'd5});
        wait_idle();
        rd(8'h00, v); check(v, {16'd100, 16'd5}, "R1 destination readback");

        // R2 plain size write only loads
        cur_tag = "R2";
        reg_wr(8'h04, {16'd8, 16'd2});
        wait_idle();
        rd(8'h00, v); check(v, {16'd100, 16'd5}, "R2 plain size no fill");

        // R3/R5/R6 solid fill, clipped, two rows
        cur_tag = "R3 R5 R6 solid";
        reg_wr(8'h08, 32'hFFFF_FFFF);
        reg_wr(8'h0C, 32'h5A);
        reg_wr(8'h10, 32'h11);
        reg_wr(8'h14, 32'h2);
        expect_fill(100, 5, 40, 2, 32'hFFFF_FFFF, 8'h5A, 8'h11, 0, 1);
        reg_wr(8'h44, {16'd40, 16'd2});
        rd(8'h80, v); check({24'b0, v[31:24]} != 0, 32'd1, "R8 busy after start");
        wait_idle();
        drain_check("R3");
        rd(8'h00, v); check(v, {16'd100, 16'd7}, "R7 Y advanced by height");

        // R4 background written, R5 rounding to 32
        cur_tag = "R4 R5 stipple";
        reg_wr(8'h08, 32'hA500_0001);
        reg_wr(8'h14, 32'h0);
        expect_fill(100, 7, 5, 1, 32'hA500_0001, 8'h5A, 8'h11, 0, 0);
        reg_wr(8'h44, {16'd5, 16'd1});
        wait_idle();
        drain_check("R5");

        // R4 transparency with clip, and a second stacked fill
        cur_tag = "R4 transparent";
        reg_wr(8'h08, 32'h0F0F_0F0F);
        reg_wr(8'h14, 32'h3);
        expect_fill(100, 8, 20, 3, 32'h0F0F_0F0F, 8'h5A, 8'h11, 1, 1);
        reg_wr(8'h44, {16'd20, 16'd3});
        wait_idle();
        drain_check("R4");
        rd(8'h00, v); check(v, {16'd100, 16'd11}, "R7 stacked fill");

        // R11 zero width and zero height
        cur_tag = "R11";
        reg_wr(8'h44, {16'd0, 16'd4});
        reg_wr(8'h44, {16'd4, 16'd0});
        wait_idle();
        rd(8'h00, v); check(v, {16'd100, 16'd11}, "R11 Y unchanged");

        // R9/R10 queue filling during a long fill
        cur_tag = "R9 R10 long";
        reg_wr(8'h00, {16'd0, 16'd200});
        reg_wr(8'h08, 32'hFFFF_FFFF);
        reg_wr(8'h0C, 32'h77);
        reg_wr(8'h14, 32'h2);
        expect_fill(0, 200, 32, 20, 32'hFFFF_FFFF, 8'h77, 8'h11, 0, 1);
        reg_wr(8'h44, {16'd32, 16'd20});
        for (int i = 1; i <= 10; i++) reg_wr(8'h0C, 32'(i));
        rd(8'h84, v); check(v, 32'd22, "R9 free slots with 10 waiting");
        for (int i = 11; i <= 35; i++) reg_wr(8'h0C, 32'(i));
        rd(8'h84, v); check(v, 32'h8000_0000, "R10 full and overflow");
        wait_idle();
        drain_check("R9");
        rd(8'h84, v); check(v, 32'h8000_0020, "R10 overflow sticky");
        cur_tag = "R10 dropped";
        expect_fill(0, 220, 1, 1, 32'hFFFF_FFFF, 8'd32, 8'h11, 0, 1);
        reg_wr(8'h44, {16'd1, 16'd1});
        wait_idle();
        drain_check("R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule